// File: doc/BRIEF.md
# Bit-rate tick generator with half-step prescaler

This block turns the system clock into the bit-rate enable of a serial transceiver. The first stage is a prescaler whose divide factor comes from a small select code. The factor steps in halves, so values such as 6.5 are possible. An integer divisor stage follows, programmed with its divide count minus one. A last stage then divides by half the oversampling ratio in asynchronous operation, or passes every divisor event through in synchronous operation. The whole chain therefore gives a bit period of `16·N·P/2` clocks for asynchronous framing and `2·N·P/2` clocks for synchronous framing.

The output is a one-clock enable pulse and never a derived clock. Shift and framing logic elsewhere qualify their flops with it. Any change on the configuration inputs restarts every stage from zero, so a new rate takes effect at once and is not mixed with a partly finished period. Select code zero parks the generator.

For example, with a 5 MHz clock, a factor of 6.5 (code 12) and a divisor of 5 (value 4), the bit period in asynchronous operation is 260 clocks. That gives about 19231 bit/s, 0.16 % above 19200.

Top module: `baud_gen`

## Requirements
- R1: A select code c (1 to 2^PSEL_W−1) sets the prescale factor P=(c+1)/2. The j-th prescaler event after a restart falls on clock ceil(j·(c+1)/2), so odd codes divide evenly and even codes alternate between floor(P) and ceil(P).
- R2: A divisor value d gives N=d+1 prescaler events per divisor event. For example, d=4 divides by 5.
- R3: With sync_mode=0 (asynchronous), one baud_tick is issued per OVS/2 divisor events, which is 8 with the default OVS=16. The bit period is therefore 8·N·P clocks on average.
- R4: With sync_mode=1 (synchronous), one baud_tick is issued per divisor event, giving a bit period of N·P clocks on average.
- R5: While the select code is 0, baud_tick stays low in every following clock.
- R6: A change on presc_sel, div_val or sync_mode restarts all stages. Take the clock edge that first sees the new values as edge 0, and let T=N·F·(c+1), with F=8 in asynchronous and 1 in synchronous mode. Then baud_tick is low after edge 0 and is high after edge k exactly when floor(2k/T) differs from floor(2(k−1)/T).
- R7: baud_tick is high in two consecutive clocks only when sync_mode=1, d=0 and c≤2.
- R8: While rst_n is low, baud_tick is low.
- R9: Code 12, divisor value 4, asynchronous: the first tick after a restart falls on edge 260, and ticks follow every 260 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| presc_sel | input | PSEL_W | Prescaler select code; factor (c+1)/2, 0 disables |
| div_val | input | DIV_W | Divisor minus one |
| sync_mode | input | 1 | 0 asynchronous (divide by OVS/2 after the divisor), 1 synchronous |
| baud_tick | output | 1 | One-clock bit-rate enable |

## Verification
The bench sweeps every select code, every divisor value and both modes of a reduced configuration. On every edge it compares the tick against the floor formula of R6. A prescaler that rounded half steps up or down would drift by one clock per pair of periods. An off-by-one on the stored divisor would stretch every period by a factor (N+1)/N. A wrong final ratio would show up only in asynchronous mode. Targeted runs also cover the following cases:
- the 6.5 × 5 example at exactly 260 clocks;
- a mid-period change of the divisor alone, which catches a design that keeps its old count;
- the disabled code 0, where a leaking tick would be seen at once.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } baud_mode_e;

  // Width able to hold values 0..v-1, at least one bit.
  function automatic int unsigned cnt_width(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/baud_half_presc.sv
// Half-step prescaler: the accumulator moves in half-clock units, two per
// clock, and fires when it reaches twice the factor (p2 = 2*P).
module baud_half_presc #(
  parameter int unsigned ACC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ACC_W-1:0] p2,
  output logic             fire
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W:0]   sum;
  logic             hit;

  always_comb begin
    sum  = {1'b0, acc_q} + (ACC_W+1)'(2);
    hit  = (sum >= {1'b0, p2});
    fire = hit && !clr;
    if (clr) begin
      acc_d = '0;
    end else if (hit) begin
      acc_d = ACC_W'(sum - {1'b0, p2});
    end else begin
      acc_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/baud_stage_cnt.sv
// Integer stage: counts step pulses, wraps after limit+1 of them.
module baud_stage_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] limit,
  output logic          wrap
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_top;

  always_comb begin
    at_top = (cnt_q == limit);
    wrap   = step && at_top && !clr;
    if (clr) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = at_top ? '0 : cnt_q + CW'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int unsigned PSEL_W = 5,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PSEL_W-1:0] presc_sel,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              sync_mode,
  output logic              baud_tick
);

  localparam int unsigned ACC_W   = PSEL_W + 2;
  localparam int unsigned FIN_DIV = OVS / 2;
  localparam int unsigned FIN_W   = cnt_width(FIN_DIV);

  logic              rst_s;
  logic [PSEL_W-1:0] sel_q;
  logic [DIV_W-1:0]  div_q;
  logic              mode_q;
  logic              cfg_chg;
  logic              clr;
  logic [ACC_W-1:0]  p2;
  logic              pre_fire;
  logic              div_wrap;
  logic              fin_wrap;
  logic              tick_d;
  logic              tick_q;
  baud_mode_e        mode;

  baud_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  always_comb begin
    mode    = baud_mode_e'(sync_mode);
    cfg_chg = (presc_sel != sel_q) || (div_val != div_q) || (sync_mode != mode_q);
    clr     = cfg_chg || (presc_sel == '0);
    p2      = ACC_W'(presc_sel) + ACC_W'(1);
    tick_d  = fin_wrap;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      sel_q  <= '0;
      div_q  <= '0;
      mode_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      sel_q  <= presc_sel;
      div_q  <= div_val;
      mode_q <= sync_mode;
      tick_q <= tick_d;
    end
  end

  baud_half_presc #(.ACC_W(ACC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_s),
    .clr   (clr),
    .p2    (p2),
    .fire  (pre_fire)
  );

  baud_stage_cnt #(.CW(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_s),
    .clr   (clr),
    .step  (pre_fire),
    .limit (div_val),
    .wrap  (div_wrap)
  );

  generate
    if (FIN_DIV > 1) begin : g_fin
      logic [FIN_W-1:0] fin_limit;
      always_comb begin
        fin_limit = (mode == MODE_SYNC) ? '0 : FIN_W'(FIN_DIV - 1);
      end
      baud_stage_cnt #(.CW(FIN_W)) u_fin (
        .clk   (clk),
        .rst_n (rst_s),
        .clr   (clr),
        .step  (div_wrap),
        .limit (fin_limit),
        .wrap  (fin_wrap)
      );
    end else begin : g_nofin
      assign fin_wrap = div_wrap;
    end
  endgenerate

  assign baud_tick = tick_q;

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int unsigned PSEL_W = 5,
  parameter int unsigned DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PSEL_W-1:0] presc_sel,
  input logic [DIV_W-1:0]  div_val,
  input logic              sync_mode,
  input logic              baud_tick
);

  assert_off_when_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_sel == '0) |=> !baud_tick);

  assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(presc_sel) || !$stable(div_val) || !$stable(sync_mode)) |=> !baud_tick);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && $past(baud_tick)) |->
      ($past(sync_mode) && ($past(div_val) == '0) && ($past(presc_sel) <= PSEL_W'(2))));

  assert_reset_low_R8: assert property (@(posedge clk)
    !rst_n |-> !baud_tick);

endmodule

bind baud_gen baud_gen_chk #(.PSEL_W(PSEL_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/baud_gen_test.sv
module baud_gen_test;

  localparam int unsigned PSEL_W = 4;
  localparam int unsigned DIV_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [PSEL_W-1:0] presc_sel;
  logic [DIV_W-1:0]  div_val;
  logic              sync_mode;
  logic              baud_tick;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  baud_gen #(.PSEL_W(PSEL_W), .DIV_W(DIV_W), .OVS(16)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_sel (presc_sel),
    .div_val   (div_val),
    .sync_mode (sync_mode),
    .baud_tick (baud_tick)
  );

  // Apply a configuration and compare every edge against floor(2k/T).
  task automatic run_cfg(input int c, input int d, input bit m,
                         input int edges, input string tag);
    int t_half;
    int first_k;
    int act;
    int exp_v;
    bit ok;
    ok      = 1;
    first_k = -1;
    act     = 0;
    exp_v   = 0;
    t_half  = (d + 1) * (m ? 1 : 8) * (c + 1);
    @(negedge clk);
    presc_sel = PSEL_W'(c);
    div_val   = DIV_W'(d);
    sync_mode = m;
    @(posedge clk);
    #1;
    if (baud_tick !== 1'b0) begin
      ok = 0; first_k = 0; act = baud_tick; exp_v = 0;
    end
    for (int k = 1; k <= edges; k++) begin
      int e;
      @(posedge clk);
      #1;
      e = (c == 0) ? 0 : (((2 * k) / t_half) != ((2 * (k - 1)) / t_half));
      if (ok && (baud_tick !== 1'(e))) begin
        ok = 0; first_k = k; act = baud_tick; exp_v = e;
      end
    end
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s c=%0d d=%0d sync=%0d edge=%0d actual=%0d expected=%0d",
               tag, c, d, m, first_k, act, exp_v);
    end
  endtask

  initial begin
    rst_n     = 1'b1;
    presc_sel = '0;
    div_val   = '0;
    sync_mode = 1'b0;
    #2 rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (baud_tick !== 1'b0) begin
      bad++;
      $display("FAIL R8 reset actual=%0d expected=0", baud_tick);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R5: disabled code, nonzero divisor, both modes
    run_cfg(0, 3, 1'b0, 300, "R5");
    run_cfg(0, 0, 1'b1, 100, "R5");

    // R9: 6.5 x 5, asynchronous, three full periods
    run_cfg(12, 4, 1'b0, 790, "R9 R3");

    // R6: mid-period change of divisor alone, then of mode alone
    run_cfg(12, 4, 1'b0, 130, "R6");
    run_cfg(12, 2, 1'b0, 400, "R6 R2");
    run_cfg(12, 2, 1'b1, 100, "R6 R4");

    // R7 corner: fastest settings in synchronous mode
    run_cfg(1, 0, 1'b1, 20, "R7 R1");
    run_cfg(2, 0, 1'b1, 20, "R7 R1");

    // Full sweep: R1 R2 R3 R4 R6
    for (int m = 0; m < 2; m++) begin
      for (int c = 1; c < (1 << PSEL_W); c++) begin
        for (int d = 0; d < (1 << DIV_W); d++) begin
          int tt;
          tt = (d + 1) * (m ? 1 : 8) * (c + 1);
          run_cfg(c, d, 1'(m), (3 * tt + 1) / 2 + 2,
                  m ? "R1 R2 R4 R6" : "R1 R2 R3 R6");
        end
      end
    end

    // back to disabled after a running setting
    run_cfg(5, 1, 1'b1, 10, "R6");
    run_cfg(0, 1, 1'b1, 200, "R5");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule